// File: doc/BRIEF.md
# Core Clock Source and Divider Selector

This block chooses where the core clock, the tick timer clock and two peripheral bus clocks come from. Five candidate oscillators feed it. Each one arrives as a one-cycle tick pulse on a single reference clock, together with a stable flag. The outputs are clock-enable pulses, not real clocks. The core enable is the selected source's tick stream divided by a programmable N+1. The tick timer enable comes from one of five sources, three of which are halved. Each bus enable either follows the core enable or takes every second core pulse.

Software talks to the block over a simple write port that has four registers.

| Address | Register | Behaviour |
|---|---|---|
| 0 | Oscillator enables | Plain writable. |
| 1 | Status | Read-only stable flags, plus a sticky switch-failure flag that is cleared by writing 1. |
| 2 | Clock selection | Protected: it accepts writes only while the `unlock` input is high. |
| 3 | Dividers | Plain writable. |

A selection write that names a reserved code, or a source that is not currently stable, leaves that field unchanged and raises the failure flag. A valid field in the same write is still accepted.

Top module: `coreclk_selector`

## Requirements
- R1: After reset, the outputs read as follows: `osc_en_q`=4'b0100 (high-speed RC on), `clk_sel_q`=8'h07 (core from high-speed RC, tick from code 000, both buses undivided), `clk_div_q`=0 and `status_q[7]`=0.
- R2: A write to address 0 loads `wr_data[3:0]` into `osc_en_q`, where bit 0 is the high-speed crystal, bit 1 the low-speed crystal, bit 2 the high-speed RC and bit 3 the low-speed RC. The status bits are:
  - bit 0: `src_stable[0]`&`osc_en_q[0]`
  - bit 1: `src_stable[1]`&`osc_en_q[1]`
  - bit 2: `src_stable[2]` (the PLL)
  - bit 3: `src_stable[3]`&`osc_en_q[3]`
  - bit 4: `src_stable[4]`&`osc_en_q[2]`
  - bits 6:5: always 0

  Source indices are 0 for the high-speed crystal, 1 for the low-speed crystal, 2 for the PLL, 3 for the low-speed RC and 4 for the high-speed RC.
- R3: A write to address 2 while `unlock` is low changes neither `clk_sel_q` nor `status_q[7]`.
- R4: An unlocked write to address 2 loads the core field `wr_data[2:0]` when its code is valid and the status bit of its source is 1. The valid codes are 000 (source 0), 001 (source 1), 010 (source 2), 011 (source 3) and 111 (source 4).
- R5: If the core code is reserved (100, 101 or 110), or its source status bit is 0, the core field keeps its old value and `status_q[7]` is set.
- R6: The tick field `wr_data[5:3]` is accepted under these rules, otherwise kept with `status_q[7]` set:
  - code 000 needs status bit 0
  - code 001 needs status bit 1
  - code 010 needs status bit 0
  - code 011 is always accepted
  - code 111 needs status bit 4
  - codes 100, 101 and 110 are reserved and always rejected
- R7: `status_q[7]` stays set until a write to address 1 with `wr_data[7]`=1. A write with `wr_data[7]`=0 leaves it set.
- R8: A write to address 3 stores `wr_data` masked to bits [23:16], [11:8], [7:4] and [3:0]. All other bits read 0.
- R9: `hclk_en` pulses on the selected source tick that completes each group of `clk_div_q[3:0]`+1 ticks. With the divider at 0 it follows every selected tick. When the count already reaches a newly lowered divider value, the next tick fires.
- R10: `systick_en` depends on the tick field:
  - 000: source 0 ticks
  - 001: source 1 ticks
  - 010: every second source 0 tick
  - 011: every second `hclk_en` pulse
  - 111: every second source 4 tick

  The halvers free-run from reset and fire on the 2nd, 4th and later input pulses.
- R11: `pclk0_en` equals `hclk_en` when `clk_sel_q[6]`=0 and follows every second `hclk_en` pulse when it is 1. `pclk1_en` does the same under `clk_sel_q[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 5 | Tick pulses of the five candidate sources |
| src_stable | input | 5 | Stable flags of the five sources |
| unlock | input | 1 | High permits writes to the selection register |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 32 | Write data |
| osc_en_q | output | 4 | Oscillator enable register |
| status_q | output | 8 | Status register |
| clk_sel_q | output | 8 | Clock selection register |
| clk_div_q | output | 32 | Divider register |
| hclk_en | output | 1 | Core clock enable pulse |
| systick_en | output | 1 | Tick timer clock enable pulse |
| pclk0_en | output | 1 | Bus 0 clock enable pulse |
| pclk1_en | output | 1 | Bus 1 clock enable pulse |

## Verification
The hardest case to reach is a selection write in which one field is accepted and the other is rejected, in the same cycle that a source's stable flag or enable bit drops. The failure flag and the partial update then both depend on the status that the write sees in that cycle.

The directed part drops the PLL flag and writes reserved codes. The random part toggles the stable flags each cycle with a bias, mixes locked and unlocked writes to every address, and rewrites the enable register. A bench model checks every field of the outputs each cycle.

The divider wrap is exercised by lowering the divider while a count is in progress.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int NUM_SRC = 5;
  localparam int SRC_W   = 3;

  localparam logic [1:0] ADDR_OSC  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_SEL  = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;

  localparam logic [31:0] DIV_KEEP = 32'h00FF_0FFF;

  // Core source code is legal.
  function automatic logic core_code_ok(input logic [2:0] code);
    return (code[2] == 1'b0) || (code == 3'b111);
  endfunction

  // Core source code to source index.
  function automatic logic [SRC_W-1:0] core_code_src(input logic [2:0] code);
    return (code == 3'b111) ? SRC_W'(4) : {1'b0, code[1:0]};
  endfunction

  // Tick code accepted given the status flags.
  function automatic logic tick_code_ok(input logic [2:0] code, input logic [4:0] stab);
    case (code)
      3'b000, 3'b010: return stab[0];
      3'b001:         return stab[1];
      3'b011:         return 1'b1;
      3'b111:         return stab[4];
      default:        return 1'b0;
    endcase
  endfunction

  // Divider reaches terminal count.
  function automatic logic div_terminal(input logic [3:0] cnt, input logic [3:0] lim);
    return cnt >= lim;
  endfunction
endpackage

// File: rtl/ccs_regs.sv
module ccs_regs
  import ccs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               unlock,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [NUM_SRC-1:0] src_stable,
  output logic [3:0]         osc_en_q,
  output logic [7:0]         status_q,
  output logic [7:0]         clk_sel_q,
  output logic [31:0]        clk_div_q,
  output logic               sel_reject
);
  logic [4:0] stab;
  logic       fail_q;
  logic       sel_wr, core_ok, tick_ok, fail_clr;
  logic [2:0] core_code, tick_code;

  assign stab[0] = src_stable[0] & osc_en_q[0];
  assign stab[1] = src_stable[1] & osc_en_q[1];
  assign stab[2] = src_stable[2];
  assign stab[3] = src_stable[3] & osc_en_q[3];
  assign stab[4] = src_stable[4] & osc_en_q[2];
  assign status_q = {fail_q, 2'b00, stab};

  assign sel_wr    = wr_en && (wr_addr == ADDR_SEL) && unlock;
  assign core_code = wr_data[2:0];
  assign tick_code = wr_data[5:3];
  assign core_ok   = core_code_ok(core_code) && stab[core_code_src(core_code)];
  assign tick_ok   = tick_code_ok(tick_code, stab);
  assign sel_reject = sel_wr && !(core_ok && tick_ok);
  assign fail_clr  = wr_en && (wr_addr == ADDR_STAT) && wr_data[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_en_q  <= 4'b0100;
      clk_sel_q <= 8'h07;
      clk_div_q <= '0;
      fail_q    <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_OSC) osc_en_q <= wr_data[3:0];
      if (wr_en && wr_addr == ADDR_DIV) clk_div_q <= wr_data & DIV_KEEP;
      if (sel_wr) begin
        if (core_ok) clk_sel_q[2:0] <= core_code;
        if (tick_ok) clk_sel_q[5:3] <= tick_code;
        clk_sel_q[7:6] <= wr_data[7:6];
      end
      if (sel_reject)    fail_q <= 1'b1;
      else if (fail_clr) fail_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ccs_clkdiv.sv
module ccs_clkdiv
  import ccs_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic [DIV_W-1:0] div_n,
  output logic             pulse
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap  = div_terminal(cnt_q, div_n);
  assign pulse = tick_in && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_in) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ccs_halve.sv
module ccs_halve (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic half_pulse
);
  logic phase_q;

  assign half_pulse = tick_in && phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= 1'b0;
    else if (tick_in) phase_q <= ~phase_q;
  end
endmodule

// File: rtl/coreclk_selector.sv
module coreclk_selector
  import ccs_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [NUM_SRC-1:0] src_stable,
  input  logic               unlock,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [31:0]        wr_data,
  output logic [3:0]         osc_en_q,
  output logic [7:0]         status_q,
  output logic [7:0]         clk_sel_q,
  output logic [31:0]        clk_div_q,
  output logic               hclk_en,
  output logic               systick_en,
  output logic               pclk0_en,
  output logic               pclk1_en
);
  localparam int NUM_HALF = 3;

  logic                sel_reject;
  logic                hclk_tick;
  logic [NUM_HALF-1:0] half_in, half_out;

  ccs_regs u_regs (
    .clk(clk), .rst_n(rst_n), .unlock(unlock), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .src_stable(src_stable),
    .osc_en_q(osc_en_q), .status_q(status_q), .clk_sel_q(clk_sel_q),
    .clk_div_q(clk_div_q), .sel_reject(sel_reject)
  );

  assign hclk_tick = src_tick[core_code_src(clk_sel_q[2:0])];

  ccs_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_in(hclk_tick),
    .div_n(clk_div_q[DIV_W-1:0]), .pulse(hclk_en)
  );

  // Halver inputs: 0 high-speed crystal, 1 high-speed RC, 2 core enable.
  assign half_in = {hclk_en, src_tick[4], src_tick[0]};

  for (genvar g = 0; g < NUM_HALF; g++) begin : g_half
    ccs_halve u_half (
      .clk(clk), .rst_n(rst_n), .tick_in(half_in[g]), .half_pulse(half_out[g])
    );
  end

  always_comb begin
    case (clk_sel_q[5:3])
      3'b000:  systick_en = src_tick[0];
      3'b001:  systick_en = src_tick[1];
      3'b010:  systick_en = half_out[0];
      3'b011:  systick_en = half_out[2];
      3'b111:  systick_en = half_out[1];
      default: systick_en = 1'b0;
    endcase
  end

  assign pclk0_en = clk_sel_q[6] ? half_out[2] : hclk_en;
  assign pclk1_en = clk_sel_q[7] ? half_out[2] : hclk_en;
endmodule

// File: rtl/ccs_checker.sv
module ccs_checker
  import ccs_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        unlock,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic [7:0]  status_q,
  input logic [7:0]  clk_sel_q,
  input logic [31:0] clk_div_q,
  input logic        hclk_tick,
  input logic        hclk_en,
  input logic        pclk0_en,
  input logic        pclk1_en,
  input logic        sel_reject
);
  p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_SEL && !unlock) |=> $stable(clk_sel_q));

  p_reserved_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_SEL && unlock && wr_data[2] && wr_data[1:0] != 2'b11)
      |=> (clk_sel_q[2:0] == $past(clk_sel_q[2:0])) && status_q[7]);

  p_reject_sets_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_reject |=> status_q[7]);

  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[7] && !(wr_en && wr_addr == ADDR_STAT && wr_data[7])) |=> status_q[7]);

  p_status_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[6:5] == 2'b00);

  p_div_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_div_q & ~DIV_KEEP) == 32'h0);

  p_hclk_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hclk_en |-> hclk_tick);

  p_div_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_div_q[3:0] == 4'd0 && hclk_tick) |-> hclk_en);

  p_bus_sub_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pclk0_en || pclk1_en) |-> hclk_en);
endmodule

bind coreclk_selector ccs_checker u_ccs_checker (
  .clk(clk), .rst_n(rst_n), .unlock(unlock), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .status_q(status_q), .clk_sel_q(clk_sel_q),
  .clk_div_q(clk_div_q), .hclk_tick(hclk_tick), .hclk_en(hclk_en),
  .pclk0_en(pclk0_en), .pclk1_en(pclk1_en), .sel_reject(sel_reject)
);

// File: tb/coreclk_selector_bench.sv
`timescale 1ns/1ps
module coreclk_selector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  src_tick = '0, src_stable = '0;
  logic        unlock = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  osc_en_q;
  logic [7:0]  status_q, clk_sel_q;
  logic [31:0] clk_div_q;
  logic        hclk_en, systick_en, pclk0_en, pclk1_en;

  int compared = 0, mismatched = 0;
  bit done = 0;
  int n_h, n_s, n_p0, n_p1;

  // Bench model state
  logic [3:0]  m_en;
  logic [7:0]  m_sel;
  logic [31:0] m_div;
  logic        m_fail;
  int          m_cnt;
  bit          ph_x, ph_i, ph_h;

  always #4 clk = ~clk;

  coreclk_selector u_coreclk_selector (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_stable(src_stable),
    .unlock(unlock), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .osc_en_q(osc_en_q), .status_q(status_q), .clk_sel_q(clk_sel_q),
    .clk_div_q(clk_div_q), .hclk_en(hclk_en), .systick_en(systick_en),
    .pclk0_en(pclk0_en), .pclk1_en(pclk1_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] b_stab(input logic [3:0] en, input logic [4:0] st);
    return {st[4] & en[2], st[3] & en[3], st[2], st[1] & en[1], st[0] & en[0]};
  endfunction

  function automatic int b_core_idx(input logic [2:0] c);
    case (c)
      3'd0: return 0; 3'd1: return 1; 3'd2: return 2; 3'd3: return 3; 3'd7: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic bit b_tick_ok(input logic [2:0] c, input logic [4:0] s);
    if (c == 3'd3) return 1;
    if (c == 3'd0 || c == 3'd2) return s[0];
    if (c == 3'd1) return s[1];
    if (c == 3'd7) return s[4];
    return 0;
  endfunction

  task automatic model_reset();
    m_en = 4'b0100; m_sel = 8'h07; m_div = 0; m_fail = 0; m_cnt = 0;
    ph_x = 0; ph_i = 0; ph_h = 0;
  endtask

  // One reference cycle: drive, compare, advance model.
  task automatic step(input logic [4:0] tk, input logic [4:0] st, input logic ul,
                      input logic we, input logic [1:0] ad, input logic [31:0] d);
    logic [4:0] s;
    bit e_h, e_s, e_p0, e_p1, selt;
    int ci, tc;
    @(negedge clk);
    src_tick = tk; src_stable = st; unlock = ul; wr_en = we; wr_addr = ad; wr_data = d;
    #1;
    s    = b_stab(m_en, st);
    selt = tk[b_core_idx(m_sel[2:0])];
    e_h  = selt && (int'(m_div[3:0]) - m_cnt <= 0);
    case (m_sel[5:3])
      3'd0: e_s = tk[0];
      3'd1: e_s = tk[1];
      3'd2: e_s = tk[0] && ph_x;
      3'd3: e_s = e_h && ph_h;
      3'd7: e_s = tk[4] && ph_i;
      default: e_s = 0;
    endcase
    e_p0 = m_sel[6] ? (e_h && ph_h) : e_h;
    e_p1 = m_sel[7] ? (e_h && ph_h) : e_h;
    check("R2 osc_en", osc_en_q, m_en);
    check("R2 R7 status", status_q, {m_fail, 2'b00, s});
    check("R3 R4 R5 R6 clk_sel", clk_sel_q, m_sel);
    check("R8 clk_div", clk_div_q, m_div);
    check("R9 hclk_en", hclk_en, e_h);
    check("R10 systick_en", systick_en, e_s);
    check("R11 pclk0_en", pclk0_en, e_p0);
    check("R11 pclk1_en", pclk1_en, e_p1);
    n_h += hclk_en; n_s += systick_en; n_p0 += pclk0_en; n_p1 += pclk1_en;
    // advance
    if (selt) m_cnt = (int'(m_div[3:0]) - m_cnt <= 0) ? 0 : m_cnt + 1;
    if (tk[0]) ph_x = !ph_x;
    if (tk[4]) ph_i = !ph_i;
    if (e_h)   ph_h = !ph_h;
    if (we) begin
      case (ad)
        2'd0: m_en = d[3:0];
        2'd1: if (d[7]) m_fail = 0;
        2'd2: if (ul) begin
          ci = b_core_idx(d[2:0]);
          if (ci >= 0 && s[ci]) m_sel[2:0] = d[2:0]; else m_fail = 1;
          if (b_tick_ok(d[5:3], s)) m_sel[5:3] = d[5:3]; else m_fail = 1;
          m_sel[7:6] = d[7:6];
        end
        default: m_div = {8'h0, d[23:16], 4'h0, d[11:0]};
      endcase
    end
    tc = 0;
  endtask

  task automatic idle(input logic [4:0] st);
    step(5'h00, st, 1'b0, 1'b0, 2'd0, 32'h0);
  endtask

  task automatic wr(input logic [4:0] st, input logic ul, input logic [1:0] ad, input logic [31:0] d);
    step(5'h00, st, ul, 1'b1, ad, d);
    idle(st);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd2024);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(5'h1F);
    // R1 reset values
    check("R1 osc_en reset", osc_en_q, 4'b0100);
    check("R1 clk_sel reset", clk_sel_q, 8'h07);
    check("R1 clk_div reset", clk_div_q, 0);
    check("R1 fail reset", status_q[7], 0);
    // R2 enable all, status mapping
    wr(5'h1F, 1'b0, 2'd0, 32'hFFFF_FFFF);
    check("R2 osc_en masked", osc_en_q, 4'hF);
    check("R2 status all stable", status_q, 8'h1F);
    // R3 locked write
    wr(5'h1F, 1'b0, 2'd2, 32'h0000_0002);
    check("R3 locked write kept", clk_sel_q, 8'h07);
    check("R3 no fail", status_q[7], 0);
    // R5 PLL unstable
    wr(5'h1B, 1'b1, 2'd2, 32'h0000_0002);
    check("R5 unstable kept", clk_sel_q[2:0], 3'b111);
    check("R5 fail set", status_q[7], 1);
    // R7 write 0 keeps, write 1 clears
    wr(5'h1F, 1'b0, 2'd1, 32'h0000_0000);
    check("R7 sticky", status_q[7], 1);
    wr(5'h1F, 1'b0, 2'd1, 32'h0000_0080);
    check("R7 cleared", status_q[7], 0);
    // R5 reserved code, tick field still accepted
    wr(5'h1F, 1'b1, 2'd2, 32'h0000_000D);
    check("R5 reserved core kept", clk_sel_q, 8'h0F);
    check("R5 reserved fail", status_q[7], 1);
    wr(5'h1F, 1'b0, 2'd1, 32'h80);
    // R6 reserved tick code
    wr(5'h1F, 1'b1, 2'd2, 32'h0000_0020);
    check("R6 reserved tick kept", clk_sel_q, 8'h08);
    check("R6 fail", status_q[7], 1);
    wr(5'h1F, 1'b0, 2'd1, 32'h80);
    // R4 valid: core HXT, tick HCLK/2, bus1 halved
    wr(5'h1F, 1'b1, 2'd2, 32'h0000_0098);
    check("R4 accepted", clk_sel_q, 8'h98);
    check("R4 no fail", status_q[7], 0);
    // R8 divider mask; R9 divide by 3
    wr(5'h1F, 1'b0, 2'd3, 32'hFFFF_FFF2);
    check("R8 div mask", clk_div_q, 32'h00FF_0FF2);
    n_h = 0; n_s = 0; n_p0 = 0; n_p1 = 0;
    for (int i = 0; i < 30; i++) step(5'h1F, 5'h1F, 1'b0, 1'b0, 2'd0, 0);
    check("R9 divide by 3 count", n_h, 10);
    check("R10 hclk/2 tick count", n_s, 5);
    check("R11 pclk0 full count", n_p0, 10);
    check("R11 pclk1 half count", n_p1, 5);
    // Lower divider mid-count
    for (int i = 0; i < 2; i++) step(5'h01, 5'h1F, 1'b0, 1'b0, 2'd0, 0);
    step(5'h00, 5'h1F, 1'b0, 1'b1, 2'd3, 32'h1);
    for (int i = 0; i < 6; i++) step(5'h01, 5'h1F, 1'b0, 1'b0, 2'd0, 0);
    // Random phase
    for (int i = 0; i < 6000; i++) begin
      logic [4:0] tk, st;
      logic we, ul;
      logic [1:0] ad;
      logic [31:0] d;
      tk = 5'($urandom);
      st = 5'($urandom) | 5'($urandom);
      we = ($urandom % 4) == 0;
      ul = ($urandom % 3) != 0;
      ad = 2'($urandom);
      d  = $urandom;
      if (ad == 2'd0) d[2] = 1'b1;
      if (ad == 2'd3) d[3:2] = 2'b00;
      step(tk, st, ul, we, ad, d);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule